// File: doc/BRIEF.md
# SPI Controller Event and FIFO Status Unit

This unit sits between a word-oriented SPI shifter and the register bus of a SPI controller. It holds a transmit queue and a receive queue of 32-bit words, keeps a set of event flags that describe their state and the progress of a transfer, and raises an interrupt when an event the host has chosen to see is present. Software writes the mode register to switch the controller on, stores the two FIFO threshold fields there, and writes the mask register to select which events may interrupt.

Events come in two kinds. Level events (receive has data, transmit has room) follow the queue occupancy and return on their own after software clears them. Latched events (transmit drained, transfer finished, and four sticky error bits for rejected pushes and pops) stay set until software writes a one to their position. Next to the flags the event register shows a live receive byte count. Switching the enable bit off empties both queues but keeps the thresholds and the mask.

Top module: `spi_status_unit`

## Requirements
- R1: After reset the mode, event and mask registers read 0 and `irq` is low.
- R2: The mode register (address 0) keeps the enable in bit 31, the transmit threshold in bits 11:8 and the receive threshold in bits 3:0. All other bits read 0.
- R3: Each queue holds DEPTH words of 32 bits in arrival order. The head word is shown on its data output while the queue is not empty. A push and a pop in the same cycle are both accepted when the queue is neither full nor empty as seen before that edge.
- R4: Event register (address 1) bits 29:24 show four times the number of words in the receive queue. The field changes on the same edge as the queue.
- R5: Event bit 9 (receive not empty) and bit 8 (transmit not full) are updated one edge after the occupancy they reflect and read 0 while the unit is disabled. A write-one-to-clear holds the bit at 0 for one cycle, after which it returns if its condition still holds.
- R6: Event bit 15 latches when an accepted transmit pop takes the last word. Bit 14 latches on a `xfer_done` pulse while the unit is enabled. When a set and a clear of the same bit happen in one cycle, the set wins.
- R7: A write to the event register clears exactly the latched bits written as 1. Writing all ones clears every latched event.
- R8: A push into a full queue or a pop from an empty queue does not change that queue. It sets a sticky event bit: transmit overflow bit 0, transmit underflow bit 1, receive overflow bit 2, receive underflow bit 3.
- R9: While the enable bit is 0, both queues are empty and pushes, pops and `xfer_done` have no effect and set no flag. The thresholds and the mask keep their values.
- R10: `irq` is the OR of (event flags AND mask), registered one cycle. A mask of 0 keeps `irq` low whatever the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 mode, 1 event, 2 mask |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| tx_push | input | 1 | Host pushes a word into the transmit queue |
| tx_data_in | input | 32 | Word to push into the transmit queue |
| tx_pop | input | 1 | Shifter takes the transmit head word |
| tx_data_out | output | 32 | Transmit head word |
| rx_push | input | 1 | Shifter pushes a received word |
| rx_data_in | input | 32 | Received word |
| rx_pop | input | 1 | Host takes the receive head word |
| rx_data_out | output | 32 | Receive head word |
| xfer_done | input | 1 | Pulse from the shifter at the end of a transfer |
| irq | output | 1 | Interrupt request |

## Verification
The queue contents, the receive byte field and every latched flag change on the edge that samples the stimulus. The two level flags follow one edge later. `irq` follows one edge after the flags it covers, so it trails a level condition by two edges. The bench drives each stimulus one nanosecond after a rising edge. Its model computes the post-edge state from the pre-edge state in the same order as these delays, then samples every output one nanosecond after the next rising edge. Directed sections check the one-cycle gap after a level-flag clear, set-over-clear, overflow on exactly the ninth push, and disable with configuration kept. A fixed-seed random phase mixes all of these.

// File: rtl/spi_stat_pkg.sv
`timescale 1ns/1ps
package spi_stat_pkg;
    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        ADDR_MODE = 2'd0,
        ADDR_EVT  = 2'd1,
        ADDR_MASK = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // event flag positions
    localparam int unsigned EV_TXE   = 15;
    localparam int unsigned EV_DON   = 14;
    localparam int unsigned EV_RNE   = 9;
    localparam int unsigned EV_TNF   = 8;
    localparam int unsigned EV_TXOVF = 0;
    localparam int unsigned EV_TXUNF = 1;
    localparam int unsigned EV_RXOVF = 2;
    localparam int unsigned EV_RXUNF = 3;
    localparam int unsigned CNT_LSB  = 24;
    localparam int unsigned CNT_W    = 6;

    // mode register positions
    localparam int unsigned MODE_EN   = 31;
    localparam int unsigned TXTHR_LSB = 8;
    localparam int unsigned RXTHR_LSB = 0;

    localparam logic [31:0] LATCH_BITS = (32'd1 << EV_TXE) | (32'd1 << EV_DON) |
                                         (32'd1 << EV_TXOVF) | (32'd1 << EV_TXUNF) |
                                         (32'd1 << EV_RXOVF) | (32'd1 << EV_RXUNF);
endpackage

// File: rtl/spi_word_fifo.sv
`timescale 1ns/1ps
module spi_word_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          ovf,
    output logic          unf
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [W-1:0] mem_q [DEPTH];
    logic full, empty, push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (st_q.cnt == CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        push_ok = en && push && !full;
        pop_ok  = en && pop && !empty;
        st_d    = st_q;
        if (!en) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wp = bump(st_q.wp);
            if (pop_ok)  st_d.rp = bump(st_q.rp);
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= wdata;
    end

    assign rdata = mem_q[st_q.rp];
    assign count = st_q.cnt;
    assign ovf   = en && push && full;
    assign unf   = en && pop && empty;

    // R3: occupancy never exceeds the depth
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    // R8: a rejected push alone leaves the queue as it was
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && push && full && !pop) |=> $stable(st_q.cnt));
    // R9: disabled queue is empty on the next cycle
    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.cnt == '0));
endmodule

// File: rtl/spi_evt_regs.sv
`timescale 1ns/1ps
module spi_evt_regs
    import spi_stat_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned THR_W = 4,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          xfer_done,
    input  logic          tx_pop,
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] rx_cnt,
    input  logic          tx_ovf,
    input  logic          tx_unf,
    input  logic          rx_ovf,
    input  logic          rx_unf,
    output logic          en,
    output logic          irq
);
    typedef struct packed {
        logic             en;
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
        logic [31:0]      mask;
        logic [31:0]      flags;
        logic             irq;
    } regs_st_t;

    regs_st_t st_q, st_d;
    logic [31:0] w1c, set_v;
    logic [CNT_W-1:0] rx_bytes;

    always_comb begin
        w1c   = (bus_wr && bus_addr == ADDR_EVT) ? bus_wdata : '0;
        set_v = '0;
        set_v[EV_TXE]   = st_q.en && tx_pop && (tx_cnt == CW'(1));
        set_v[EV_DON]   = st_q.en && xfer_done;
        set_v[EV_TXOVF] = tx_ovf;
        set_v[EV_TXUNF] = tx_unf;
        set_v[EV_RXOVF] = rx_ovf;
        set_v[EV_RXUNF] = rx_unf;

        st_d = st_q;
        st_d.flags = ((st_q.flags & ~w1c) | set_v) & LATCH_BITS;
        st_d.flags[EV_RNE] = st_q.en && (rx_cnt != '0) && !w1c[EV_RNE];
        st_d.flags[EV_TNF] = st_q.en && (tx_cnt != CW'(DEPTH)) && !w1c[EV_TNF];
        st_d.irq = |(st_q.flags & st_q.mask);

        if (bus_wr && bus_addr == ADDR_MODE) begin
            st_d.en     = bus_wdata[MODE_EN];
            st_d.tx_thr = bus_wdata[TXTHR_LSB +: THR_W];
            st_d.rx_thr = bus_wdata[RXTHR_LSB +: THR_W];
        end
        if (bus_wr && bus_addr == ADDR_MASK) st_d.mask = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rx_bytes  = CNT_W'({rx_cnt, 2'b00});
        bus_rdata = '0;
        case (bus_addr)
            ADDR_MODE: begin
                bus_rdata[MODE_EN]               = st_q.en;
                bus_rdata[TXTHR_LSB +: THR_W]    = st_q.tx_thr;
                bus_rdata[RXTHR_LSB +: THR_W]    = st_q.rx_thr;
            end
            ADDR_EVT: begin
                bus_rdata                        = st_q.flags;
                bus_rdata[CNT_LSB +: CNT_W]      = rx_bytes;
            end
            ADDR_MASK: bus_rdata = st_q.mask;
            default:   bus_rdata = '0;
        endcase
    end

    assign en  = st_q.en;
    assign irq = st_q.irq;

    // R10: a zero mask keeps the interrupt low on the next cycle
    assert_mask_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |=> !st_q.irq);
    // R9 / R5: level flags are low after a disabled cycle
    assert_disabled_levels_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |=> (!st_q.flags[EV_RNE] && !st_q.flags[EV_TNF]));
    // R6: clearing the drained flag without a new set leaves it low
    assert_w1c_txe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c[EV_TXE] && !set_v[EV_TXE]) |=> !st_q.flags[EV_TXE]);
    // R8: sticky error bit holds until written with one
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flags[EV_RXOVF] && !w1c[EV_RXOVF]) |=> st_q.flags[EV_RXOVF]);
endmodule

// File: rtl/spi_status_unit.sv
`timescale 1ns/1ps
module spi_status_unit
    import spi_stat_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned THR_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tx_push,
    input  logic [31:0] tx_data_in,
    input  logic        tx_pop,
    output logic [31:0] tx_data_out,
    input  logic        rx_push,
    input  logic [31:0] rx_data_in,
    input  logic        rx_pop,
    output logic [31:0] rx_data_out,
    input  logic        xfer_done,
    output logic        irq
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic          en;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_ovf, tx_unf, rx_ovf, rx_unf;

    spi_word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .en(en),
        .push(tx_push), .wdata(tx_data_in), .pop(tx_pop), .rdata(tx_data_out),
        .count(tx_cnt), .ovf(tx_ovf), .unf(tx_unf)
    );

    spi_word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .en(en),
        .push(rx_push), .wdata(rx_data_in), .pop(rx_pop), .rdata(rx_data_out),
        .count(rx_cnt), .ovf(rx_ovf), .unf(rx_unf)
    );

    spi_evt_regs #(.DEPTH(DEPTH), .THR_W(THR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xfer_done(xfer_done), .tx_pop(tx_pop), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .tx_ovf(tx_ovf), .tx_unf(tx_unf), .rx_ovf(rx_ovf), .rx_unf(rx_unf),
        .en(en), .irq(irq)
    );
endmodule

// File: tb/spi_status_unit_test.sv
`timescale 1ns/1ps
module spi_status_unit_test;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        wr, txp, txo, rxp, rxo, done;
    logic [1:0]  addr;
    logic [31:0] wdata, txd, rxd;
    logic [31:0] rdata, tx_out, rx_out;
    logic        irq;

    spi_status_unit #(.DEPTH(DEPTH), .THR_W(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .tx_push(txp), .tx_data_in(txd), .tx_pop(txo), .tx_data_out(tx_out),
        .rx_push(rxp), .rx_data_in(rxd), .rx_pop(rxo), .rx_data_out(rx_out),
        .xfer_done(done), .irq(irq)
    );

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    logic        m_en = 1'b0, m_rne = 1'b0, m_tnf = 1'b0, m_irq = 1'b0;
    logic [31:0] m_mask = '0, m_lat = '0;

    task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_event();
        logic [31:0] v = m_lat;
        v[9] = m_rne;
        v[8] = m_tnf;
        v[29:24] = 6'(rxq.size() * 4);
        return v;
    endfunction

    task automatic idle();
        wr = 1'b0; addr = 2'd1; wdata = '0;
        txp = 1'b0; txo = 1'b0; rxp = 1'b0; rxo = 1'b0; done = 1'b0;
        txd = '0; rxd = '0;
    endtask

    task automatic step();
        logic [31:0] w1c, setv, lat_n;
        logic rne_n, tnf_n, irq_n;
        int txs = txq.size();
        int rxs = rxq.size();
        w1c   = (wr && addr == 2'd1) ? wdata : '0;
        irq_n = |((m_lat | (32'(m_rne) << 9) | (32'(m_tnf) << 8)) & m_mask);
        rne_n = m_en && rxs > 0 && !w1c[9];
        tnf_n = m_en && txs < DEPTH && !w1c[8];
        setv  = '0;
        if (m_en) begin
            if (txo) begin
                if (txs == 0) setv[1] = 1'b1;
                else begin void'(txq.pop_front()); if (txs == 1) setv[15] = 1'b1; end
            end
            if (txp) begin
                if (txs == DEPTH) setv[0] = 1'b1; else txq.push_back(txd);
            end
            if (rxo) begin
                if (rxs == 0) setv[3] = 1'b1; else void'(rxq.pop_front());
            end
            if (rxp) begin
                if (rxs == DEPTH) setv[2] = 1'b1; else rxq.push_back(rxd);
            end
            if (done) setv[14] = 1'b1;
        end else begin
            txq.delete();
            rxq.delete();
        end
        lat_n = ((m_lat & ~w1c) | setv) & 32'h0000_C00F;
        if (wr && addr == 2'd0) m_en = wdata[31];
        if (wr && addr == 2'd2) m_mask = wdata;
        @(posedge clk); #1;
        m_lat = lat_n; m_rne = rne_n; m_tnf = tnf_n; m_irq = irq_n;
        if (addr == 2'd1) check32(cur_req, "event", rdata, exp_event());
        check32(cur_req, "irq", 32'(irq), 32'(m_irq));
        if (rxq.size() > 0) check32(cur_req, "rx head", rx_out, rxq[0]);
        if (txq.size() > 0) check32(cur_req, "tx head", tx_out, txq[0]);
        idle();
    endtask

    task automatic wr_reg(logic [1:0] a, logic [31:0] d);
        addr = a; wr = 1'b1; wdata = d;
        step();
    endtask

    task automatic chk_reg(logic [1:0] a, logic [31:0] exp, string what);
        addr = a; #1;
        check32(cur_req, what, rdata, exp);
        addr = 2'd1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        idle();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        cur_req = "R1";
        chk_reg(2'd0, 32'h0, "mode after reset");
        chk_reg(2'd1, 32'h0, "event after reset");
        chk_reg(2'd2, 32'h0, "mask after reset");
        check32("R1", "irq after reset", 32'(irq), 32'h0);

        // R2 mode fields and unused bits
        cur_req = "R2";
        wr_reg(2'd0, 32'hFFFF_FFFF);
        chk_reg(2'd0, 32'h8000_0F0F, "mode all ones");
        wr_reg(2'd0, 32'h8000_0305);
        chk_reg(2'd0, 32'h8000_0305, "mode value");

        // R5 level flags and R4 byte count
        cur_req = "R5";
        step();
        step();
        cur_req = "R4";
        rxp = 1'b1; rxd = 32'hA5A5_0001; step();
        check32("R4", "count field same edge", 32'(rdata[29:24]), 32'd4);
        cur_req = "R5";
        step();
        check32("R5", "rne one edge later", 32'(rdata[9]), 32'd1);
        wr_reg(2'd1, 32'h0000_0300);
        check32("R5", "rne after clear", 32'(rdata[9]), 32'd0);
        step();
        check32("R5", "rne returns", 32'(rdata[9]), 32'd1);

        // R3 ordering, simultaneous push and pop
        cur_req = "R3";
        for (int i = 0; i < 3; i++) begin
            txp = 1'b1; txd = 32'h1111_0000 + 32'(i); step();
        end
        txp = 1'b1; txo = 1'b1; txd = 32'h2222_0000; step();
        rxo = 1'b1; step();
        check32("R3", "rx drained", 32'(rdata[29:24]), 32'd0);
        for (int i = 0; i < 3; i++) begin
            txo = 1'b1; step();
        end

        // R6 drained and done flags, set beats clear
        cur_req = "R6";
        check32("R6", "txe latched", 32'(rdata[15]), 32'd1);
        wr_reg(2'd1, 32'h0000_8000);
        check32("R6", "txe cleared", 32'(rdata[15]), 32'd0);
        done = 1'b1; wr = 1'b1; wdata = 32'h0000_4000; step();
        check32("R6", "done set wins", 32'(rdata[14]), 32'd1);

        // R8 overflow and underflow
        cur_req = "R8";
        for (int i = 0; i < DEPTH + 1; i++) begin
            rxp = 1'b1; rxd = 32'h3300_0000 + 32'(i); step();
        end
        check32("R8", "rx ovf bit2", 32'(rdata[2]), 32'd1);
        check32("R8", "rx count full", 32'(rdata[29:24]), 32'd32);
        txo = 1'b1; step();
        check32("R8", "tx unf bit1", 32'(rdata[1]), 32'd1);
        for (int i = 0; i < DEPTH + 1; i++) begin
            txp = 1'b1; txd = 32'h4400_0000 + 32'(i); step();
        end
        check32("R8", "tx ovf bit0", 32'(rdata[0]), 32'd1);
        for (int i = 0; i < DEPTH + 1; i++) begin
            rxo = 1'b1; step();
        end
        check32("R8", "rx unf bit3", 32'(rdata[3]), 32'd1);

        // R7 selective and full clear
        cur_req = "R7";
        wr_reg(2'd1, 32'h0000_0004);
        check32("R7", "only bit2 cleared", rdata & 32'h0000_C00F, 32'h0000_400B);
        wr_reg(2'd1, 32'hFFFF_FFFF);
        check32("R7", "all latched cleared", rdata & 32'h0000_C30F, 32'h0);
        step();

        // R10 interrupt masking
        cur_req = "R10";
        done = 1'b1; step();
        step(); step();
        check32("R10", "mask zero no irq", 32'(irq), 32'd0);
        wr_reg(2'd2, 32'h0000_4000);
        step();
        check32("R10", "irq from done", 32'(irq), 32'd1);
        wr_reg(2'd1, 32'h0000_4000);
        step();
        check32("R10", "irq drops", 32'(irq), 32'd0);

        // R9 disable keeps configuration
        cur_req = "R9";
        wr_reg(2'd0, 32'h0000_0305);
        step();
        check32("R9", "count flushed", 32'(rdata[29:24]), 32'd0);
        txp = 1'b1; rxo = 1'b1; done = 1'b1; step();
        step();
        check32("R9", "no flags when disabled", rdata, 32'h0);
        chk_reg(2'd0, 32'h0000_0305, "thresholds kept");
        chk_reg(2'd2, 32'h0000_4000, "mask kept");
        wr_reg(2'd0, 32'h8000_0305);
        step();

        // random mix covering R3 R4 R5 R6 R8 R10
        cur_req = "R3 R4 R5 R6 R8 R10 random";
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 250) wr_reg(2'd2, $urandom());
            if (i == 2000) begin wr_reg(2'd0, 32'h0000_0305); step(); wr_reg(2'd0, 32'h8000_0305); end
            txp = 1'($urandom() % 2); txd = $urandom();
            txo = ($urandom() % 3) == 0;
            rxp = ($urandom() % 3) == 0; rxd = $urandom();
            rxo = 1'($urandom() % 2);
            done = ($urandom() % 16) == 0;
            if (($urandom() % 8) == 0) begin wr = 1'b1; addr = 2'd1; wdata = $urandom(); end
            step();
        end

        summary();
        $finish;
    end
endmodule